// File: doc/BRIEF.md
# Counted-bit serial transfer engine

This block runs one framed transaction at a time on a single-lane serial memory bus. A frame is described entirely by the byte stream that feeds it. The leading byte gives how many bits go out to the memory, and the byte after it gives how many bits come back. The payload bytes that follow are shifted out, most significant bit first. When the read count is non-zero, the engine inserts one dummy clock after the last written bit and then samples the memory's data line. It packs the received bits into bytes on an output stream.

Chip select is driven low only for the body of the frame. The frame closes with a deselect window in which the serial clock is held high for one full serial period. The serial clock rate is set by a parameter, `HALF_DIV`, which counts system clocks per half serial period.

Top module: `serial_xfer_engine`

## Requirements
- R1: The first byte accepted while idle is the write-bit count and the second is the read-bit count; every byte after them, up to ceil(write count / 8), is payload.
- R2: While the two count bytes are being taken, cs_n is 1 and sck is 0.
- R3: Payload bits leave on mosi MSB first, one per sck pulse. Each bit is valid while sck is low and stays stable across the rising edge. A fresh payload byte is requested after every 8 bits.
- R4: With a read count of 0, the number of rising sck edges seen with cs_n low equals the write count exactly.
- R5: With a non-zero read count, exactly one dummy sck pulse follows the written bits, so the rising edges with cs_n low number write count + 1 + read count.
- R6: Each received bit is sampled from miso at the moment sck is driven low after its high half. Bits are packed MSB first, and the first bit is the one the memory drives after the dummy pulse.
- R7: A received byte is offered only once 8 bits are collected. A read count that is not a multiple of 8 ends with a partial byte whose bits sit at the top, with zeros below.
- R8: The frame ends with cs_n high and sck high for exactly 2*HALF_DIV system clocks, after which sck returns low.
- R9: Every high half of sck inside a frame lasts exactly HALF_DIV system clocks.
- R10: busy rises with the acceptance of the write-count byte and falls after the deselect window. in_ready is high whenever busy is low, and low while bits are being shifted.
- R11: While out_valid is high and out_ready is low, out_data holds its value and the serial clock pauses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| in_data | input | 8 | Count and payload byte stream |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts an input byte |
| out_data | output | 8 | Received byte |
| out_valid | output | 1 | Received byte valid |
| out_ready | input | 1 | Consumer accepts the received byte |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |
| busy | output | 1 | A frame is in progress |

## Verification
The bench aims at the edges of the counting scheme:
- A frame with both counts zero. A design that miscounts it would pulse sck or skip the deselect window.
- A write-only frame. A design that always adds the dummy pulse would report one rising edge too many.
- A read-only frame and a one-bit frame, which expose any off-by-one in the count checks.
- Write and read counts that are not multiples of 8. These show whether a partial payload byte is cut short and whether a partial received byte comes out right-justified or with stale low bits.
- Output backpressure. A design that keeps clocking while stalled would lose bits or change the offered byte.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE, ST_LOADR, ST_FETCH,
        ST_WLO, ST_WHI, ST_TLO, ST_THI,
        ST_RLO, ST_RHI, ST_PUSH, ST_ENDA, ST_ENDB
    } sxe_state_e;

    typedef struct packed {
        sxe_state_e        st;
        logic [BYTE_W-1:0] wleft;
        logic [BYTE_W-1:0] rleft;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rx;
        logic [BIT_W-1:0]  bitn;
    } sxe_regs_t;

    function automatic logic is_timed(sxe_state_e s);
        return (s == ST_WLO) || (s == ST_WHI) || (s == ST_TLO) || (s == ST_THI) ||
               (s == ST_RLO) || (s == ST_RHI) || (s == ST_ENDA) || (s == ST_ENDB);
    endfunction
endpackage

// File: rtl/sxe_half_tick.sv
module sxe_half_tick #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_full_rate
            assign tick = run;
        end else begin : g_divided
            localparam int DW = $clog2(HALF_DIV);
            logic [DW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = '0;
                if (run && (cnt_q != DW'(HALF_DIV - 1))) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = run && (cnt_q == DW'(HALF_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/sxe_ctrl.sv
module sxe_ctrl
    import sxe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic              run,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              busy
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    sxe_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    r_d.wleft = in_data;
                    r_d.st    = ST_LOADR;
                end
            end
            ST_LOADR: begin
                if (in_valid) begin
                    r_d.rleft = in_data;
                    if (r_q.wleft != '0)     r_d.st = ST_FETCH;
                    else if (in_data != '0)  r_d.st = ST_TLO;
                    else                     r_d.st = ST_ENDA;
                end
            end
            ST_FETCH: begin
                if (in_valid) begin
                    r_d.sh   = in_data;
                    r_d.bitn = '0;
                    r_d.st   = ST_WLO;
                end
            end
            ST_WLO: if (tick) r_d.st = ST_WHI;
            ST_WHI: begin
                if (tick) begin
                    r_d.sh    = {r_q.sh[BYTE_W-2:0], 1'b0};
                    r_d.bitn  = r_q.bitn + 1'b1;
                    r_d.wleft = r_q.wleft - 1'b1;
                    if (r_q.wleft == BYTE_W'(1))
                        r_d.st = (r_q.rleft != '0) ? ST_TLO : ST_ENDA;
                    else if (r_q.bitn == LAST_BIT)
                        r_d.st = ST_FETCH;
                    else
                        r_d.st = ST_WLO;
                end
            end
            ST_TLO: if (tick) r_d.st = ST_THI;
            ST_THI: begin
                if (tick) begin
                    r_d.bitn = '0;
                    r_d.rx   = '0;
                    r_d.st   = ST_RLO;
                end
            end
            ST_RLO: if (tick) r_d.st = ST_RHI;
            ST_RHI: begin
                if (tick) begin
                    r_d.rx[LAST_BIT - r_q.bitn] = miso;
                    r_d.bitn  = r_q.bitn + 1'b1;
                    r_d.rleft = r_q.rleft - 1'b1;
                    if ((r_q.bitn == LAST_BIT) || (r_q.rleft == BYTE_W'(1)))
                        r_d.st = ST_PUSH;
                    else
                        r_d.st = ST_RLO;
                end
            end
            ST_PUSH: begin
                if (out_ready) begin
                    r_d.rx   = '0;
                    r_d.bitn = '0;
                    r_d.st   = (r_q.rleft == '0) ? ST_ENDA : ST_RLO;
                end
            end
            ST_ENDA: if (tick) r_d.st = ST_ENDB;
            ST_ENDB: if (tick) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign run       = is_timed(r_q.st);
    assign in_ready  = (r_q.st == ST_IDLE) || (r_q.st == ST_LOADR) || (r_q.st == ST_FETCH);
    assign out_valid = (r_q.st == ST_PUSH);
    assign out_data  = r_q.rx;
    assign sck       = (r_q.st == ST_WHI) || (r_q.st == ST_THI) || (r_q.st == ST_RHI) ||
                       (r_q.st == ST_ENDA) || (r_q.st == ST_ENDB);
    assign cs_n      = (r_q.st == ST_IDLE) || (r_q.st == ST_LOADR) ||
                       (r_q.st == ST_ENDA) || (r_q.st == ST_ENDB);
    assign mosi      = ((r_q.st == ST_WLO) || (r_q.st == ST_WHI)) ? r_q.sh[BYTE_W-1] : 1'b0;
    assign busy      = (r_q.st != ST_IDLE);
endmodule

// File: rtl/serial_xfer_engine.sv
module serial_xfer_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    input  logic       out_ready,
    output logic       sck,
    output logic       cs_n,
    output logic       mosi,
    input  logic       miso,
    output logic       busy
);
    logic run;
    logic tick;

    sxe_half_tick #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    sxe_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .miso      (miso),
        .busy      (busy)
    );
endmodule

// File: rtl/sxe_checker.sv
module sxe_checker #(
    parameter int HALF_DIV = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi,
    input logic       busy
);
    localparam int CW = $clog2(HALF_DIV + 2);
    logic [CW-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt_q <= '0;
        else if (sck && !cs_n) hi_cnt_q <= (hi_cnt_q == CW'(HALF_DIV)) ? hi_cnt_q : hi_cnt_q + 1'b1;
        else                   hi_cnt_q <= '0;
    end

    assert_idle_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sck));

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> in_ready);

    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck && $past(sck) && !$past(cs_n)) |-> $stable(mosi));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(sck)));

    assert_deselect_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> sck);

    assert_half_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && !cs_n) |-> (hi_cnt_q < CW'(HALF_DIV)));
endmodule

bind serial_xfer_engine sxe_checker #(.HALF_DIV(HALF_DIV)) i_sxe_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .busy      (busy)
);

// File: tb/test_serial_xfer_engine.sv
`timescale 1ns/1ps
module test_serial_xfer_engine;
    localparam int HD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       sck, cs_n, mosi;
    logic       miso = 1'b0;
    logic       busy;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    serial_xfer_engine #(.HALF_DIV(HD)) i_serial_xfer_engine (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
        .out_ready(out_ready), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .busy(busy)
    );

    // {write count, read count, payload (MSB first), read pattern, backpressure}
    localparam int NV = 9;
    localparam logic [80:0] VEC [NV] = '{
        {8'd8,  8'd0,  32'hA500_0000, 32'h0000_0000, 1'b0},
        {8'd16, 8'd8,  32'h9F3C_0000, 32'hC300_0000, 1'b0},
        {8'd12, 8'd0,  32'hF0A0_0000, 32'h0000_0000, 1'b0},
        {8'd0,  8'd8,  32'h0000_0000, 32'h5A00_0000, 1'b0},
        {8'd8,  8'd13, 32'h0B00_0000, 32'hB2E7_0000, 1'b0},
        {8'd32, 8'd32, 32'hDEAD_BEEF, 32'h1234_5678, 1'b1},
        {8'd0,  8'd0,  32'h0000_0000, 32'h0000_0000, 1'b0},
        {8'd1,  8'd1,  32'h8000_0000, 32'h8000_0000, 1'b0},
        {8'd24, 8'd20, 32'h0211_2200, 32'hA5F0_F000, 1'b1}
    };

    // Memory model: records mosi on rising sck, drives miso for read bits.
    int          edges = 0;
    int          base = 0;
    int          cur_wc = 0;
    logic [31:0] cur_rx = '0;
    logic [63:0] cap = '0;
    always @(posedge sck) begin
        if (!cs_n) begin
            int e;
            e = edges - base;
            if (e < 64) cap[e] = mosi;
            if ((e >= cur_wc + 1) && (e - cur_wc - 1 < 32)) miso = cur_rx[31 - (e - cur_wc - 1)];
            edges = edges + 1;
        end
    end

    // Output collector with optional backpressure and hold check.
    logic [7:0] got [64];
    int   rx_total = 0;
    int   hold_err = 0;
    int   cyc = 0;
    logic bp_mode = 1'b0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = '0;
    int   hcnt = 0, last_hi = 0, ecnt = 0, last_end = 0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_stall && (!out_valid || out_data != prev_data)) hold_err = hold_err + 1;
        out_ready = bp_mode ? (cyc % 4 == 0) : 1'b1;
        if (out_valid && out_ready) begin
            got[rx_total % 64] = out_data;
            rx_total = rx_total + 1;
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (!cs_n && sck) hcnt = hcnt + 1;
        else if (hcnt != 0) begin last_hi = hcnt; hcnt = 0; end
        if (cs_n && sck) ecnt = ecnt + 1;
        else if (ecnt != 0) begin last_end = ecnt; ecnt = 0; end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run did not finish (act=hung exp=done)");
        summary();
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_vec(input logic [80:0] v);
        logic [7:0]  wc, rc;
        logic [31:0] tx, rp;
        int ntx, nrx, rbase, hbase, exp_edges;
        logic ok;
        wc = v[80:73]; rc = v[72:65]; tx = v[64:33]; rp = v[32:1];
        base = edges; cur_wc = int'(wc); cur_rx = rp; bp_mode = v[0];
        rbase = rx_total; hbase = hold_err;
        ntx = (int'(wc) + 7) / 8;
        nrx = (int'(rc) + 7) / 8;
        chk(cs_n && !sck && !busy, "R2 idle before write count", {busy, sck, cs_n}, 3'b001);
        push(wc);
        chk(cs_n && !sck && busy, "R2 R10 loading read count", {busy, sck, cs_n}, 3'b101);
        push(rc);
        for (int b = 0; b < ntx; b++) push(tx[31 - 8*b -: 8]);
        wait_idle();
        exp_edges = int'(wc) + ((rc != 0) ? 1 + int'(rc) : 0);
        chk(edges - base == exp_edges, (rc == 0) ? "R4 edge count" : "R5 edge count",
            edges - base, exp_edges);
        ok = 1'b1;
        for (int k = 0; k < int'(wc); k++) if (cap[k] !== tx[31 - k]) ok = 1'b0;
        chk(ok, "R1 R3 mosi bits", int'(cap[31:0]), int'(tx));
        chk(rx_total - rbase == nrx, "R7 received byte count", rx_total - rbase, nrx);
        for (int i = 0; i < nrx; i++) begin
            logic [7:0] e;
            for (int j = 0; j < 8; j++) e[7 - j] = (8*i + j < int'(rc)) ? rp[31 - 8*i - j] : 1'b0;
            chk(got[(rbase + i) % 64] == e, "R6 R7 received byte", got[(rbase + i) % 64], e);
        end
        chk(last_end == 2*HD, "R8 deselect window", last_end, 2*HD);
        if (exp_edges > 0) chk(last_hi == HD, "R9 high half length", last_hi, HD);
        if (v[0]) chk(hold_err == hbase, "R11 stalled output held", hold_err - hbase, 0);
        chk(!busy && in_ready, "R10 idle after frame", {busy, in_ready}, 2'b01);
        bp_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sck && !busy && in_ready && !out_valid && !mosi, "R2 R10 reset state",
            {cs_n, sck, busy, in_ready, out_valid, mosi}, 6'b100100);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NV; n++) run_vec(VEC[n]);

        // Directed: no input accepted while shifting.
        base = edges; cur_wc = 8;
        push(8'd8);
        push(8'd0);
        chk(busy, "R10 busy after counts", busy, 1);
        push(8'h3C);
        chk(!in_ready, "R10 not ready while shifting", in_ready, 0);
        wait_idle();
        chk(cap[7:0] == 8'h3C && edges - base == 8, "R3 R4 directed write", int'(cap[7:0]), 8'h3C);

        summary();
    end
endmodule